// File: doc/BRIEF.md
# Address-Masked GPIO Data Port

This block is the data path of an eight-pin general-purpose I/O port. A direction register chooses, pin by pin, whether the port drives the pin or listens to it. A data register holds the value driven on output pins and the value captured from input pins. Software reaches the data register through a window of 256 word addresses below offset 0x400. Address bits [9:2] of an access into that window form a per-pin mask. A read returns only the selected bits. A write changes only the selected bits, and only where they are outputs. A single pin can therefore be set, cleared or tested in one bus access, with no read-modify-write sequence.

Input pins are resynchronised by two flip-flops before they reach the data register. An output pin drives its data bit. A pin set as an input drives a logic 1 on its output line, which stands for a pulled-high, undriven pin. The direction register sits at offset 0x400. Offsets above the window are decoded elsewhere, and this block does nothing with them except the direction register.

Top module: `gpio_mask_port`

## Requirements
- R1: After a synchronous reset, data and direction are all zeros, every bit of `pin_out` is 1, and reads of offset 0x3FC and offset 0x400 both return 0.
- R2: A write to offset 0x400 loads the direction register from `bus_wdata`. A read of offset 0x400 returns it. Bit value 1 means output and 0 means input.
- R3: A read at a word-aligned offset below 0x400 returns the data register ANDed with offset bits [9:2]. Bits outside the mask read as 0. Reads are combinational from the address.
- R4: A write at a word-aligned offset below 0x400 changes a data bit only where offset bits [9:2] and the direction bit are both 1. That bit takes the matching `bus_wdata` bit, and every other data bit keeps its value.
- R5: Writes to data bits whose direction bit is 0 have no effect, even when the address mask selects them.
- R6: For a pin whose direction bit is 0, the data bit takes the pin level. A change on `pin_in` shows in the data register, and so in reads, after the third rising clock edge and not after the second.
- R7: `pin_out` bit i equals data bit i when direction bit i is 1, and equals 1 when direction bit i is 0.
- R8: Accesses at offsets of 0x400 and above other than 0x400, and accesses with offset bits [1:0] not zero, change neither data nor direction, and reads there return 0.
- R9: The level on `pin_in` has no effect on data bits whose direction bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| pin_in | input | 8 | External pin levels, asynchronous |
| pin_out | output | 8 | Levels driven to the pins |

## Verification
A corrupted direction bit shows on `pin_out` right after the clock edge that stores it, because `pin_out` is decoded from the registers with no extra delay. A wrong direction bit can also make a later masked write land on, or skip, the wrong pin. A data bit that is wrong shows at once in a read whose address mask selects it. If the synchronizer has a stage too many or too few, the pin-to-read latency moves away from exactly three edges. Pin changes are therefore sampled at the second and third edge. Mask errors are caught by pairing single-bit and multi-bit addresses with data patterns whose masked and unmasked bits differ.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;

    localparam int PIN_W  = 8;
    localparam int ADDR_W = 12;
    localparam int SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_DATA = 2'd1,
        ACC_DIR  = 2'd2
    } acc_kind_e;

    // Per-pin mask carried by the word index inside the data window
    function automatic logic [PIN_W-1:0] window_mask(input logic [ADDR_W-1:0] ofs);
        return ofs[PIN_W+1:2];
    endfunction

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_mask_pkg::*;
#(
    parameter int PW = PIN_W,
    parameter int AW = ADDR_W
) (
    input  logic [AW-1:0]   addr,
    output acc_kind_e       kind,
    output logic [PW-1:0]   mask
);
    localparam logic [AW-1:0] DIR_OFS = AW'(1) << (PW + 2);

    always_comb begin
        mask = addr[PW+1:2];
        kind = ACC_NONE;
        if (addr[1:0] == 2'b00) begin
            if (addr[AW-1:PW+2] == '0)
                kind = ACC_DATA;
            else if (addr == DIR_OFS)
                kind = ACC_DIR;
        end
    end
endmodule

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [STAGES-1:0][W-1:0] stage_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)
                    stage_q[s] <= '0;
                else if (s == 0)
                    stage_q[s] <= async_in;
                else
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_data_dir_regs.sv
module gpio_data_dir_regs
    import gpio_mask_pkg::*;
#(
    parameter int PW = PIN_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  acc_kind_e     kind,
    input  logic [PW-1:0] mask,
    input  logic [PW-1:0] wdata,
    input  logic [PW-1:0] pins_sync,
    output logic [PW-1:0] data_q,
    output logic [PW-1:0] dir_q
);
    logic [PW-1:0] wr_sel;

    always_comb begin
        wr_sel = '0;
        if (we && kind == ACC_DATA)
            wr_sel = mask & dir_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            dir_q  <= '0;
        end else begin
            // outputs: masked write or hold; inputs: follow synchronized pin
            data_q <= (dir_q & ~wr_sel & data_q)
                    | (wr_sel & wdata)
                    | (~dir_q & pins_sync);
            if (we && kind == ACC_DIR)
                dir_q <= wdata;
        end
    end
endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
    import gpio_mask_pkg::*;
#(
    parameter int PW = PIN_W,
    parameter int AW = ADDR_W,
    parameter int NSYNC = SYNC_STAGES
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] bus_addr,
    input  logic [PW-1:0] bus_wdata,
    input  logic          bus_we,
    output logic [PW-1:0] bus_rdata,
    input  logic [PW-1:0] pin_in,
    output logic [PW-1:0] pin_out
);
    acc_kind_e     acc_kind;
    logic [PW-1:0] acc_mask;
    logic [PW-1:0] pin_sync_q;
    logic [PW-1:0] data_q;
    logic [PW-1:0] dir_q;

    gpio_addr_decode #(.PW(PW), .AW(AW)) u_dec (
        .addr (bus_addr),
        .kind (acc_kind),
        .mask (acc_mask)
    );

    gpio_pin_sync #(.W(PW), .STAGES(NSYNC)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (pin_in),
        .sync_out (pin_sync_q)
    );

    gpio_data_dir_regs #(.PW(PW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .we        (bus_we),
        .kind      (acc_kind),
        .mask      (acc_mask),
        .wdata     (bus_wdata),
        .pins_sync (pin_sync_q),
        .data_q    (data_q),
        .dir_q     (dir_q)
    );

    always_comb begin
        unique case (acc_kind)
            ACC_DATA: bus_rdata = data_q & acc_mask;
            ACC_DIR:  bus_rdata = dir_q;
            default:  bus_rdata = '0;
        endcase
    end

    generate
        for (genvar i = 0; i < PW; i++) begin : g_drive
            assign pin_out[i] = dir_q[i] ? data_q[i] : 1'b1;
        end
    endgenerate
endmodule

// File: rtl/gpio_mask_port_chk.sv
module gpio_mask_port_chk #(
    parameter int PW = 8,
    parameter int AW = 12
) (
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] bus_addr,
    input logic          bus_we,
    input logic [PW-1:0] bus_rdata,
    input logic [PW-1:0] pin_out,
    input logic [PW-1:0] data_q,
    input logic [PW-1:0] dir_q,
    input logic [PW-1:0] pin_sync_q
);
    localparam logic [AW-1:0] DIR_OFS = AW'(1) << (PW + 2);

    logic in_win;
    logic outside;
    logic [PW-1:0] amask;
    assign in_win  = (bus_addr[AW-1:PW+2] == '0) && (bus_addr[1:0] == 2'b00);
    assign outside = !in_win && (bus_addr != DIR_OFS);
    assign amask   = bus_addr[PW+1:2];

    // R3: unmasked bits of a window read are zero
    assert_read_masked_R3: assert property (@(posedge clk) disable iff (rst)
        in_win |-> ((bus_rdata & ~amask) == '0));

    // R4: a window write leaves unselected output bits alone
    assert_write_sel_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_we && in_win) |=> (((data_q ^ $past(data_q)) & $past(dir_q) & ~$past(amask)) == '0));

    // R6: input bits load the synchronized pin value
    assert_input_follow_R6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (((data_q ^ $past(pin_sync_q)) & ~$past(dir_q)) == '0));

    // R7: pins configured as inputs drive high
    assert_float_high_R7: assert property (@(posedge clk) disable iff (rst)
        ((pin_out | dir_q) == '1));

    // R8: out-of-window accesses touch nothing and read zero
    assert_outside_inert_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_we && outside) |=> ($stable(dir_q) && (((data_q ^ $past(data_q)) & $past(dir_q)) == '0)));

    assert_outside_zero_R8: assert property (@(posedge clk) disable iff (rst)
        outside |-> (bus_rdata == '0));

    // R9: without a write, output bits hold regardless of pins
    assert_out_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !bus_we |=> (((data_q ^ $past(data_q)) & $past(dir_q)) == '0));
endmodule

bind gpio_mask_port gpio_mask_port_chk #(.PW(PW), .AW(AW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_we     (bus_we),
    .bus_rdata  (bus_rdata),
    .pin_out    (pin_out),
    .data_q     (data_q),
    .dir_q      (dir_q),
    .pin_sync_q (pin_sync_q)
);

// File: tb/sim_gpio_mask_port.sv
`timescale 1ns/1ps
module sim_gpio_mask_port;
    localparam int PW = 8;
    localparam int AW = 12;
    localparam int NV = 21;

    typedef struct packed {
        logic [1:0]    op;      // 0 write, 1 read, 2 set pins
        logic [AW-1:0] addr;
        logic [PW-1:0] val;
        logic [PW-1:0] exp_rd;
        logic [PW-1:0] exp_out;
        logic [3:0]    req;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{2'd1, 12'h3FC, 8'h00, 8'h00, 8'hFF, 4'd3},  // R3 read all after reset
        '{2'd0, 12'h400, 8'h0F, 8'h00, 8'hF0, 4'd7},  // R7 low nibble outputs
        '{2'd1, 12'h400, 8'h00, 8'h0F, 8'hF0, 4'd2},  // R2 direction readback
        '{2'd0, 12'h3FC, 8'hAA, 8'h00, 8'hFA, 4'd4},  // R4 full mask write
        '{2'd1, 12'h3FC, 8'h00, 8'h0A, 8'hFA, 4'd3},  // R3
        '{2'd0, 12'h008, 8'h00, 8'h00, 8'hF8, 4'd4},  // R4 single bit clear
        '{2'd1, 12'h00C, 8'h00, 8'h00, 8'hF8, 4'd3},  // R3 mask 03
        '{2'd1, 12'h020, 8'h00, 8'h08, 8'hF8, 4'd3},  // R3 mask 08
        '{2'd2, 12'h000, 8'h5F, 8'h00, 8'hF8, 4'd9},  // R9 pins on outputs ignored
        '{2'd1, 12'h3FC, 8'h00, 8'h58, 8'hF8, 4'd6},  // R6 inputs captured
        '{2'd0, 12'h3FC, 8'hFF, 8'h00, 8'hFF, 4'd5},  // R5 write hits inputs too
        '{2'd1, 12'h3C0, 8'h00, 8'h50, 8'hFF, 4'd5},  // R5 inputs unchanged
        '{2'd0, 12'h404, 8'hFF, 8'h00, 8'hFF, 4'd8},  // R8 other register
        '{2'd1, 12'h400, 8'h00, 8'h0F, 8'hFF, 4'd8},  // R8
        '{2'd1, 12'h404, 8'h00, 8'h00, 8'hFF, 4'd8},  // R8 reads zero
        '{2'd0, 12'h800, 8'h00, 8'h00, 8'hFF, 4'd8},  // R8 high offset
        '{2'd0, 12'h3FD, 8'h00, 8'h00, 8'hFF, 4'd8},  // R8 misaligned
        '{2'd1, 12'h3FC, 8'h00, 8'h5F, 8'hFF, 4'd8},  // R8 data intact
        '{2'd0, 12'h400, 8'hFF, 8'h00, 8'h5F, 4'd7},  // R7 all outputs
        '{2'd2, 12'h000, 8'h00, 8'h00, 8'h5F, 4'd9},  // R9
        '{2'd1, 12'h3FC, 8'h00, 8'h5F, 8'h5F, 4'd9}   // R9 data intact
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] bus_addr = '0;
    logic [PW-1:0] bus_wdata = '0;
    logic          bus_we = 1'b0;
    logic [PW-1:0] bus_rdata;
    logic [PW-1:0] pin_in = '0;
    logic [PW-1:0] pin_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    gpio_mask_port u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out)
    );

    task automatic check(input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [PW-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [PW-1:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=00 expected=01");
            finish_run();
        end
    end

    initial begin
        logic [PW-1:0] rd;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        check("R1 pin_out", pin_out, 8'hFF);
        bus_read(12'h3FC, rd); check("R1 data", rd, 8'h00);
        bus_read(12'h400, rd); check("R1 dir", rd, 8'h00);

        for (int k = 0; k < NV; k++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", VECS[k].req, k);
            case (VECS[k].op)
                2'd0: bus_write(VECS[k].addr, VECS[k].val);
                2'd1: begin
                    bus_read(VECS[k].addr, rd);
                    check(tag, rd, VECS[k].exp_rd);
                end
                default: begin
                    @(negedge clk) pin_in = VECS[k].val;
                    repeat (3) @(posedge clk);
                    @(negedge clk);
                end
            endcase
            #1 check({tag, " pin_out"}, pin_out, VECS[k].exp_out);
        end

        // R1 reset mid-run clears everything
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        pin_in = 8'h00;
        check("R1 pin_out after reset", pin_out, 8'hFF);
        bus_read(12'h400, rd); check("R1 dir after reset", rd, 8'h00);
        repeat (3) @(posedge clk);
        bus_read(12'h3FC, rd); check("R1 data after reset", rd, 8'h00);

        // R6 latency: visible after third edge, not second
        @(negedge clk) pin_in = 8'hC3; bus_addr = 12'h3FC;
        @(posedge clk); @(posedge clk);
        @(negedge clk); check("R6 two edges", bus_rdata, 8'h00);
        @(posedge clk);
        @(negedge clk); check("R6 three edges", bus_rdata, 8'hC3);

        // R4 and R7: single output bit set via one-hot mask
        bus_write(12'h400, 8'h01);
        bus_write(12'h004, 8'hFF);
        #1 check("R7 bit0 driven", pin_out, 8'hFF);
        bus_write(12'h004, 8'h00);
        #1 check("R7 bit0 cleared", pin_out, 8'hFE);
        bus_read(12'h3FC, rd); check("R4 only bit0 changed", rd, 8'hC2);

        done = 1'b1;
        finish_run();
    end
endmodule